// File: doc/BRIEF.md
# Role-Switching Three-Wire Serial Configuration Port

This block is the serial port of a radio receiver. It can act in either of two roles on the same wires, and one mode pin chooses the role. With the mode pin low, the port is a slave. An external controller clocks the serial clock and sends a command byte, then a data byte. The command either loads one of three 8-bit configuration registers or returns a register's value on the slave-out line. With the mode pin high, the port is a master. It drives the serial clock and the data line from the receive path. If the data-manager enable bit is set, it sends the regenerated bit clock and the recovered data. If the bit is clear, it passes the raw demodulated stream through onto the data line.

All pins are synchronised into the internal clock domain, and clock edges are detected there. On every change of the mode pin, the port releases both of its bidirectional drivers for a guard interval before the new role takes over. After reset the registers hold their defaults and the data manager is off. A receiver whose mode pin is tied high therefore works on its own, with no controller attached.

Top module: `spi_role_port`

## Requirements
- R1: After reset, the control register reads 0x00, the identification register reads 0x5A and the auxiliary register reads 0x00. The slave-out line is low, and both output enables are low while the mode pin is low.
- R2: In slave role, bits are sampled on the falling serial-clock edge, most significant bit first. The first byte is a command: bit 7 = 0 means write, bit 7 = 1 means read, bits 1:0 are the register index (0 control, 1 identification, 2 auxiliary), and bits 6:2 are ignored. On a write, the second byte is loaded into the indexed register.
- R3: On a read command, the slave-out line presents the indexed register during the second byte, most significant bit first. It changes after each rising serial-clock edge, so each bit is valid at the falling edge that follows.
- R4: A write to index 3 changes no register, and a read of index 3 returns 0x00.
- R5: Bit 7 of the control register is the data-manager enable.
- R6: In master role with the data manager enabled and the receive-active input high, the serial-clock output equals the regenerated clock and the data output equals the received data, one internal clock later. Both output enables are high.
- R7: In master role with the data manager enabled and receive-active low, the serial-clock output and the data output are held low.
- R8: In master role with the data manager disabled, the data output follows the raw demodulated input one internal clock later, and the serial-clock output stays low.
- R9: After every change of the synchronised mode pin, both output enables are low for at least the guard interval. When leaving slave role, the enables become high exactly SYNC_STAGES + 1 + GUARD_CYC internal clocks after the pin change.
- R10: In slave role, both output enables and both master outputs are low. Outside slave role, the slave-out line is low and serial-clock activity on the input changes no register.
- R11: Byte framing restarts each time slave role is entered. A partial byte left over from a previous visit does not shift the next transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low power-on reset |
| mode_pin | input | 1 | Role select: low = slave (configuration), high = master (operation) |
| sclk_in | input | 1 | Serial clock as seen on the pin (driven by controller in slave role) |
| mosi_in | input | 1 | Data line as seen on the pin (controller data in slave role) |
| miso | output | 1 | Slave-out read-back data |
| sclk_out | output | 1 | Serial-clock value driven in master role |
| sclk_oe | output | 1 | Enable for the serial-clock pin driver |
| mosi_out | output | 1 | Data-line value driven in master role |
| mosi_oe | output | 1 | Enable for the data-line pin driver |
| rx_active | input | 1 | Receive path has a message in progress |
| rx_clk | input | 1 | Regenerated bit clock from the receive path |
| rx_data | input | 1 | Recovered data bit from the receive path |
| rx_raw | input | 1 | Raw demodulated stream |
| reg_ctrl | output | 8 | Control register (bit 7 = data-manager enable) |
| reg_id | output | 8 | Identification word register |
| reg_aux | output | 8 | Auxiliary register |

## Verification
In master role, the forwarding path and the idle-forcing path decide the same output register in one cycle. This happens whenever the receive-active input falls while the regenerated clock and data are still high. The bench provokes it by holding clock and data high and dropping only receive-active. It expects both serial outputs to go low on the very next internal clock, not to carry one more high bit. A second collision is a write commit and a role change meeting near the same edge. The bench sends serial-clock traffic while the mode pin is high, then reads the register back in slave role to show it was left alone.

// File: rtl/spi_role_pkg.sv
package spi_role_pkg;

  typedef enum logic [1:0] {
    ROLE_SLAVE  = 2'd0,
    ROLE_GUARD  = 2'd1,
    ROLE_MASTER = 2'd2
  } role_t;

  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 2;
  localparam int REG_COUNT = 3;
  localparam int CNT_W     = $clog2(BYTE_W);

  // Command byte decode: top bit chooses read, low bits choose register
  function automatic logic cmd_is_read(input logic [BYTE_W-1:0] cmd);
    return cmd[BYTE_W-1];
  endfunction

  function automatic logic [IDX_W-1:0] cmd_index(input logic [BYTE_W-1:0] cmd);
    return cmd[IDX_W-1:0];
  endfunction

  function automatic logic index_valid(input logic [IDX_W-1:0] idx);
    return int'(idx) < REG_COUNT;
  endfunction

  // Master-role pin values
  function automatic logic fwd_clk(input logic dm_en, input logic active,
                                   input logic bit_clk);
    return dm_en & active & bit_clk;
  endfunction

  function automatic logic fwd_data(input logic dm_en, input logic active,
                                    input logic data, input logic raw);
    return dm_en ? (active & data) : raw;
  endfunction

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsp_regs.sv
module rsp_regs
  import spi_role_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEF_CTRL = 8'h00,
  parameter logic [BYTE_W-1:0] DEF_ID   = 8'h5A,
  parameter logic [BYTE_W-1:0] DEF_AUX  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_index,
  output logic [BYTE_W-1:0] rd_value,
  output logic [BYTE_W-1:0] reg_ctrl,
  output logic [BYTE_W-1:0] reg_id,
  output logic [BYTE_W-1:0] reg_aux
);
  localparam logic [REG_COUNT*BYTE_W-1:0] DEFAULTS = {DEF_AUX, DEF_ID, DEF_CTRL};

  logic [BYTE_W-1:0] bank [REG_COUNT];

  generate
    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank[r] <= DEFAULTS[r*BYTE_W +: BYTE_W];
        else if (wr_stb && index_valid(wr_index) && wr_index == MY_IDX)
          bank[r] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_value = '0;
    for (int r = 0; r < REG_COUNT; r++)
      if (rd_index == IDX_W'(r)) rd_value = bank[r];
  end

  assign reg_ctrl = bank[0];
  assign reg_id   = bank[1];
  assign reg_aux  = bank[2];
endmodule

// File: rtl/rsp_slave.sv
module rsp_slave
  import spi_role_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_value,
  output logic [IDX_W-1:0]  rd_index,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_index,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              miso
);
  logic              sclk_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic              in_data;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] cmd_q;
  logic [BYTE_W-1:0] out_sh;
  logic              miso_q;
  logic              last_bit;
  logic [BYTE_W-1:0] byte_done;

  assign sclk_rise = enable &  sclk_s & ~sclk_d;
  assign sclk_fall = enable & ~sclk_s &  sclk_d;
  assign last_bit  = (bit_cnt == CNT_W'(BYTE_W-1));
  assign byte_done = {shreg[BYTE_W-2:0], mosi_s};

  assign rd_index = cmd_index(cmd_q);
  assign wr_index = cmd_index(cmd_q);
  assign wr_data  = byte_done;
  assign wr_stb   = sclk_fall & last_bit & in_data & ~cmd_is_read(cmd_q);
  assign miso     = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      in_data <= 1'b0;
      shreg   <= '0;
      cmd_q   <= '0;
      out_sh  <= '0;
      miso_q  <= 1'b0;
    end else if (!enable) begin
      bit_cnt <= '0;
      in_data <= 1'b0;
      shreg   <= '0;
      cmd_q   <= '0;
      out_sh  <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (sclk_fall) begin
        shreg   <= byte_done;
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          if (!in_data) begin
            cmd_q   <= byte_done;
            in_data <= 1'b1;
          end else begin
            in_data <= 1'b0;
          end
        end
      end
      if (sclk_rise) begin
        if (in_data && cmd_is_read(cmd_q)) begin
          if (bit_cnt == '0) begin
            miso_q <= rd_value[BYTE_W-1];
            out_sh <= {rd_value[BYTE_W-2:0], 1'b0};
          end else begin
            miso_q <= out_sh[BYTE_W-1];
            out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
          end
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rsp_master.sv
module rsp_master
  import spi_role_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drive_en,
  input  logic dm_en,
  input  logic rx_active,
  input  logic rx_clk,
  input  logic rx_data,
  input  logic rx_raw,
  output logic sclk_out,
  output logic mosi_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_out <= 1'b0;
      mosi_out <= 1'b0;
    end else if (!drive_en) begin
      sclk_out <= 1'b0;
      mosi_out <= 1'b0;
    end else begin
      sclk_out <= fwd_clk(dm_en, rx_active, rx_clk);
      mosi_out <= fwd_data(dm_en, rx_active, rx_data, rx_raw);
    end
  end
endmodule

// File: rtl/spi_role_port.sv
module spi_role_port
  import spi_role_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                GUARD_CYC   = 2,
  parameter int                DM_BIT      = 7,
  parameter logic [BYTE_W-1:0] DEF_CTRL    = 8'h00,
  parameter logic [BYTE_W-1:0] DEF_ID      = 8'h5A,
  parameter logic [BYTE_W-1:0] DEF_AUX     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              sclk_in,
  input  logic              mosi_in,
  output logic              miso,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              rx_active,
  input  logic              rx_clk,
  input  logic              rx_data,
  input  logic              rx_raw,
  output logic [BYTE_W-1:0] reg_ctrl,
  output logic [BYTE_W-1:0] reg_id,
  output logic [BYTE_W-1:0] reg_aux
);
  localparam int GW = $clog2(GUARD_CYC + 1);

  logic [2:0]        pins_s;
  logic              mode_s, sclk_s, mosi_s;
  logic              mode_q;
  logic              mode_flip;
  role_t             role;
  logic [GW-1:0]     gcnt;
  logic              slave_now, master_now;
  logic              dm_en;

  logic              wr_stb;
  logic [IDX_W-1:0]  wr_index;
  logic [BYTE_W-1:0] wr_data;
  logic [IDX_W-1:0]  rd_index;
  logic [BYTE_W-1:0] rd_value;
  logic              sclk_rise, sclk_fall;

  rsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mode_pin, sclk_in, mosi_in}),
    .q     (pins_s)
  );
  assign {mode_s, sclk_s, mosi_s} = pins_s;

  assign mode_flip = mode_s ^ mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      role   <= ROLE_SLAVE;
      gcnt   <= '0;
    end else begin
      mode_q <= mode_s;
      if (mode_flip) begin
        role <= ROLE_GUARD;
        gcnt <= '0;
      end else if (role == ROLE_GUARD) begin
        if (gcnt == GW'(GUARD_CYC - 1)) begin
          role <= mode_q ? ROLE_MASTER : ROLE_SLAVE;
          gcnt <= '0;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
      end
    end
  end

  assign slave_now  = (role == ROLE_SLAVE);
  assign master_now = (role == ROLE_MASTER);
  assign sclk_oe    = master_now;
  assign mosi_oe    = master_now;
  assign dm_en      = reg_ctrl[DM_BIT];

  rsp_slave u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (slave_now),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .rd_value  (rd_value),
    .rd_index  (rd_index),
    .wr_stb    (wr_stb),
    .wr_index  (wr_index),
    .wr_data   (wr_data),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .miso      (miso)
  );

  rsp_regs #(
    .DEF_CTRL (DEF_CTRL),
    .DEF_ID   (DEF_ID),
    .DEF_AUX  (DEF_AUX)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_index (wr_index),
    .wr_data  (wr_data),
    .rd_index (rd_index),
    .rd_value (rd_value),
    .reg_ctrl (reg_ctrl),
    .reg_id   (reg_id),
    .reg_aux  (reg_aux)
  );

  rsp_master u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_en  (master_now),
    .dm_en     (dm_en),
    .rx_active (rx_active),
    .rx_clk    (rx_clk),
    .rx_data   (rx_data),
    .rx_raw    (rx_raw),
    .sclk_out  (sclk_out),
    .mosi_out  (mosi_out)
  );
endmodule

// File: rtl/spi_role_port_chk.sv
module spi_role_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_flip,
  input logic       slave_now,
  input logic       master_now,
  input logic       dm_en,
  input logic       wr_stb,
  input logic [1:0] wr_index,
  input logic [7:0] wr_data,
  input logic       rx_active,
  input logic       rx_clk,
  input logic       rx_data,
  input logic       rx_raw,
  input logic       miso,
  input logic       sclk_out,
  input logic       mosi_out,
  input logic       sclk_oe,
  input logic       mosi_oe,
  input logic [7:0] reg_ctrl,
  input logic [7:0] reg_id,
  input logic [7:0] reg_aux
);
  // R2: a write strobe to the identification index lands in that register
  assert_id_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_index == 2'd1 |=> reg_id == $past(wr_data));

  // R4: a write strobe to index 3 leaves the bank untouched
  assert_bad_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_index == 2'd3 |=> $stable(reg_ctrl) && $stable(reg_id) && $stable(reg_aux));

  // R6: forwarding of clock and data while a message is active
  assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_now) && $past(dm_en) && $past(rx_active)
      |-> sclk_out == $past(rx_clk) && mosi_out == $past(rx_data));

  // R7: idle master holds both lines low
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_now) && $past(dm_en) && !$past(rx_active) |-> !sclk_out && !mosi_out);

  // R8: raw pass-through with the data manager off
  assert_raw_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_now) && !$past(dm_en) |-> mosi_out == $past(rx_raw) && !sclk_out);

  // R9: every mode change opens a gap in both drivers
  assert_guard_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> !sclk_oe && !mosi_oe);

  // R10: slave-out is quiet outside slave role
  assert_miso_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_now |=> !miso);

  // R10: master outputs are quiet after a cycle in slave role
  assert_slave_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slave_now |=> !sclk_out && !mosi_out);
endmodule

bind spi_role_port spi_role_port_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_flip  (mode_flip),
  .slave_now  (slave_now),
  .master_now (master_now),
  .dm_en      (dm_en),
  .wr_stb     (wr_stb),
  .wr_index   (wr_index),
  .wr_data    (wr_data),
  .rx_active  (rx_active),
  .rx_clk     (rx_clk),
  .rx_data    (rx_data),
  .rx_raw     (rx_raw),
  .miso       (miso),
  .sclk_out   (sclk_out),
  .mosi_out   (mosi_out),
  .sclk_oe    (sclk_oe),
  .mosi_oe    (mosi_oe),
  .reg_ctrl   (reg_ctrl),
  .reg_id     (reg_id),
  .reg_aux    (reg_aux)
);

// File: tb/spi_role_port_test.sv
`timescale 1ns/1ps
module spi_role_port_test;
  localparam int SYNC_STAGES = 2;
  localparam int GUARD_CYC   = 2;
  localparam int HALF        = 6;
  localparam int NVEC        = 9;

  // {command, data, expected}: reads compare the returned byte,
  // writes compare the register named by the index (index 3 checks reg_id)
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h01, 8'h3C, 8'h3C},
    {8'h81, 8'h00, 8'h3C},
    {8'h7E, 8'h81, 8'h81},
    {8'h82, 8'h00, 8'h81},
    {8'h03, 8'hFF, 8'h3C},
    {8'h83, 8'h00, 8'h00},
    {8'h81, 8'h00, 8'h3C},
    {8'h80, 8'h00, 8'h00},
    {8'h00, 8'h80, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin = 1'b0, sclk_in = 1'b0, mosi_in = 1'b0;
  logic rx_active = 1'b0, rx_clk = 1'b0, rx_data = 1'b0, rx_raw = 1'b0;
  logic miso, sclk_out, sclk_oe, mosi_out, mosi_oe;
  logic [7:0] reg_ctrl, reg_id, reg_aux;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  spi_role_port #(.SYNC_STAGES(SYNC_STAGES), .GUARD_CYC(GUARD_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .sclk_in(sclk_in),
    .mosi_in(mosi_in), .miso(miso), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .mosi_out(mosi_out), .mosi_oe(mosi_oe), .rx_active(rx_active),
    .rx_clk(rx_clk), .rx_data(rx_data), .rx_raw(rx_raw),
    .reg_ctrl(reg_ctrl), .reg_id(reg_id), .reg_aux(reg_aux)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Controller side: drive on rising edge, capture slave-out before falling edge
  task automatic spi_pair(input logic [7:0] c, input logic [7:0] d,
                          output logic [7:0] rd);
    logic [15:0] w;
    w  = {c, d};
    rd = '0;
    for (int i = 15; i >= 0; i--) begin
      sclk_in = 1'b1;
      mosi_in = w[i];
      wait_cyc(HALF);
      if (i < 8) rd[i] = miso;
      sclk_in = 1'b0;
      wait_cyc(HALF);
    end
    mosi_in = 1'b0;
    wait_cyc(HALF);
  endtask

  function automatic logic [7:0] port_of(input logic [1:0] idx);
    case (idx)
      2'd0:    return reg_ctrl;
      2'd2:    return reg_aux;
      default: return reg_id;
    endcase
  endfunction

  task automatic set_mode(input logic m);
    mode_pin = m;
    wait_cyc(12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lat;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1: reset state
    check(reg_ctrl == 8'h00, "R1 ctrl", reg_ctrl, 8'h00);
    check(reg_id == 8'h5A, "R1 id", reg_id, 8'h5A);
    check(reg_aux == 8'h00, "R1 aux", reg_aux, 8'h00);
    check(!miso && !sclk_oe && !mosi_oe, "R1 pins", {miso, sclk_oe, mosi_oe}, 0);

    // R2 R3 R4 R5: table of transactions
    for (int v = 0; v < NVEC; v++) begin
      spi_pair(VEC[v][23:16], VEC[v][15:8], rd);
      if (VEC[v][23])
        check(rd == VEC[v][7:0], $sformatf("R3/R4 read vec %0d", v), rd, VEC[v][7:0]);
      else
        check(port_of(VEC[v][17:16]) == VEC[v][7:0], $sformatf("R2/R4 write vec %0d", v),
              port_of(VEC[v][17:16]), VEC[v][7:0]);
    end
    check(reg_ctrl[7] == 1'b1, "R5 dm enable bit", reg_ctrl, 8'h80);
    check(!sclk_out && !mosi_out && !sclk_oe, "R10 slave lines",
          {sclk_out, mosi_out, sclk_oe}, 0);

    // R9: slave to master gap length
    mode_pin = 1'b1;
    lat = 0;
    while (!sclk_oe && lat < 20) begin
      wait_cyc(1);
      lat++;
    end
    check(lat == SYNC_STAGES + 1 + GUARD_CYC, "R9 guard latency", lat,
          SYNC_STAGES + 1 + GUARD_CYC);
    check(mosi_oe, "R9 mosi enable", mosi_oe, 1);

    // R6: forwarding
    rx_active = 1'b1; rx_clk = 1'b1; rx_data = 1'b1;
    wait_cyc(1);
    check(sclk_out && mosi_out, "R6 forward high", {sclk_out, mosi_out}, 2'b11);
    rx_clk = 1'b0; rx_data = 1'b1;
    wait_cyc(1);
    check(!sclk_out && mosi_out, "R6 forward mixed", {sclk_out, mosi_out}, 2'b01);
    rx_clk = 1'b1; rx_data = 1'b0;
    wait_cyc(1);
    check(sclk_out && !mosi_out, "R6 forward mixed2", {sclk_out, mosi_out}, 2'b10);

    // R7: receive-active drops while clock and data stay high
    rx_data = 1'b1;
    wait_cyc(1);
    rx_active = 1'b0;
    wait_cyc(1);
    check(!sclk_out && !mosi_out, "R7 idle low", {sclk_out, mosi_out}, 0);
    check(miso == 1'b0, "R10 miso in master", miso, 0);

    // R10: serial traffic in operation mode writes nothing
    spi_pair(8'h01, 8'hEE, rd);
    rx_clk = 1'b0; rx_data = 1'b0;
    check(reg_id == 8'h3C, "R10 ignored write", reg_id, 8'h3C);

    // R9: master to slave releases the drivers
    mode_pin = 1'b0;
    wait_cyc(SYNC_STAGES + 1);
    check(!sclk_oe && !mosi_oe, "R9 release", {sclk_oe, mosi_oe}, 0);
    wait_cyc(8);

    // R11: partial byte, leave, return, then a clean transaction
    for (int i = 0; i < 3; i++) begin
      sclk_in = 1'b1; mosi_in = 1'b1; wait_cyc(HALF);
      sclk_in = 1'b0; wait_cyc(HALF);
    end
    mosi_in = 1'b0;
    set_mode(1'b1);
    set_mode(1'b0);
    spi_pair(8'h00, 8'h00, rd);
    check(reg_ctrl == 8'h00, "R11 framing restart", reg_ctrl, 8'h00);
    spi_pair(8'h81, 8'h00, rd);
    check(rd == 8'h3C, "R11 read after restart", rd, 8'h3C);

    // R8: raw pass-through with data manager off
    set_mode(1'b1);
    rx_active = 1'b1; rx_clk = 1'b1; rx_raw = 1'b1;
    wait_cyc(1);
    check(mosi_out && !sclk_out, "R8 raw high", {sclk_out, mosi_out}, 2'b01);
    rx_raw = 1'b0;
    wait_cyc(1);
    check(!mosi_out && !sclk_out, "R8 raw low", {sclk_out, mosi_out}, 0);
    rx_active = 1'b0; rx_clk = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule